// File: doc/BRIEF.md
# Write-Complete Acknowledge Polling Sequencer

This block runs on the master side of a two-wire serial bus. It finds out when a serial memory has finished its internal write by polling it, so the system does not have to wait out the worst-case write time. It drives a byte-level bus engine through single-cycle commands: START, byte write, byte read, repeated START and STOP. The engine reports each finished command with a done pulse and, after a byte write, with the acknowledge bit it received.

A `go` strobe starts a run and loads the device address, the next operation (write, read or none), the byte address and the write data. The sequencer then sends START and the device select with the direction bit at 0, and repeats this until the target acknowledges. An acknowledged select already counts as the first byte of the next instruction, so it is never sent again. The sequencer goes on with the byte address. For a write it then sends the data byte and STOP. For a random read it sends a repeated START, the select with the read direction, one read byte and STOP. With no next operation it sends STOP at once. A parameter caps the number of refused attempts. When the cap is reached, the run ends with STOP and an error flag.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `done` and `timeout_err` are all 0.
- R2: `go` while idle starts a run: `busy` rises on the next edge, and the first command issued is START (code 0).
- R3: Each poll attempt is START (code 0) followed by a byte write (code 1) with `cmd_wdata = {dev_addr, 1'b0}`. No command is issued until `eng_done` has closed the previous one.
- R4: If `eng_ack` is 0 at the `eng_done` of a select, the next command is START for a new attempt. `poll_cnt` counts the refused attempts of the current run.
- R5: With `op_kind = 1` (write), an acknowledged select is followed by byte write `byte_addr`, byte write `wr_data`, then STOP (code 3). The select is not sent again.
- R6: With `op_kind = 2` (read), an acknowledged select is followed by byte write `byte_addr`, RESTART (code 4), byte write `{dev_addr, 1'b1}`, READ (code 2) and STOP. `rd_data` holds the byte that the engine returned for the READ.
- R7: With `op_kind = 0` (none), an acknowledged select is followed directly by STOP.
- R8: When `MAX_POLLS` attempts have been refused, the sequencer issues STOP and sets `timeout_err`. The flag holds until the next accepted `go`, which clears it. `poll_cnt` never exceeds `MAX_POLLS`.
- R9: `done` is a one-cycle pulse, given in the cycle in which `busy` falls after the final STOP. A `go` while busy is ignored.
- R10: `cmd_valid` is a one-cycle pulse, asserted only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, accepted when idle |
| op_kind | input | 2 | Next operation: 0 none, 1 write, 2 read |
| dev_addr | input | 7 | Target device address |
| byte_addr | input | 8 | Memory byte address for the next operation |
| wr_data | input | 8 | Data byte for a write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout_err | output | 1 | The last run hit the poll limit |
| poll_cnt | output | PCW | Refused attempts in the current or last run |
| rd_data | output | 8 | Byte returned by a read |
| cmd_valid | output | 1 | Command strobe to the byte engine |
| cmd | output | 3 | 0 START, 1 WRITE, 2 READ, 3 STOP, 4 RESTART |
| cmd_wdata | output | 8 | Byte to send with WRITE |
| eng_done | input | 1 | Engine finished the current command |
| eng_ack | input | 1 | Acknowledge received, valid with `eng_done` after WRITE |
| eng_rdata | input | 8 | Byte received, valid with `eng_done` after READ |

## Verification
Some properties are checked by assertions on every cycle. These are the pulse shape of `cmd_valid` and `done`, the commands being tied to `busy`, the START that opens each run, the bound on `poll_cnt`, and a persistent `timeout_err` while idle. Other behaviour only the bench scenarios can show, by logging every engine command and comparing it with the expected list. This covers the command order for each next operation and the repeated select after each refusal. It also covers the absence of a second select after the acknowledge, the exact attempt count at the limit, the captured read byte, and a `go` during a run having no effect.

// File: rtl/ackpoll_seq.sv
module ackpoll_seq #(
  parameter int MAX_POLLS = 16,
  parameter int PCW = $clog2(MAX_POLLS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [1:0]     op_kind,
  input  logic [6:0]     dev_addr,
  input  logic [7:0]     byte_addr,
  input  logic [7:0]     wr_data,
  output logic           busy,
  output logic           done,
  output logic           timeout_err,
  output logic [PCW-1:0] poll_cnt,
  output logic [7:0]     rd_data,
  output logic           cmd_valid,
  output logic [2:0]     cmd,
  output logic [7:0]     cmd_wdata,
  input  logic           eng_done,
  input  logic           eng_ack,
  input  logic [7:0]     eng_rdata
);

  localparam logic [2:0] C_START = 3'd0, C_WRITE = 3'd1, C_READ = 3'd2,
                         C_STOP  = 3'd3, C_RSTRT = 3'd4;
  localparam logic [1:0] OP_NONE = 2'd0, OP_WR = 2'd1;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SEL, S_ADDR, S_DATA, S_RSTART, S_RSEL, S_READ, S_STOP
  } step_t;

  step_t      step;
  logic       pend;
  logic [1:0] op_q;
  logic [6:0] dev_q;
  logic [7:0] addr_q, data_q;
  logic [2:0] step_cmd;
  logic [7:0] step_byte;

  assign busy = (step != S_IDLE);

  always_comb begin
    step_cmd  = C_WRITE;
    step_byte = 8'h00;
    case (step)
      S_START:  step_cmd = C_START;
      S_SEL:    step_byte = {dev_q, 1'b0};
      S_ADDR:   step_byte = addr_q;
      S_DATA:   step_byte = data_q;
      S_RSTART: step_cmd = C_RSTRT;
      S_RSEL:   step_byte = {dev_q, 1'b1};
      S_READ:   step_cmd = C_READ;
      S_STOP:   step_cmd = C_STOP;
      default:  step_cmd = C_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step        <= S_IDLE;
      pend        <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      poll_cnt    <= '0;
      rd_data     <= 8'h00;
      cmd_valid   <= 1'b0;
      cmd         <= C_START;
      cmd_wdata   <= 8'h00;
      op_q        <= OP_NONE;
      dev_q       <= 7'h00;
      addr_q      <= 8'h00;
      data_q      <= 8'h00;
    end else begin
      done      <= 1'b0;
      cmd_valid <= 1'b0;
      if (step == S_IDLE) begin
        if (go) begin
          step        <= S_START;
          pend        <= 1'b0;
          poll_cnt    <= '0;
          timeout_err <= 1'b0;
          op_q        <= op_kind;
          dev_q       <= dev_addr;
          addr_q      <= byte_addr;
          data_q      <= wr_data;
        end
      end else if (!pend) begin
        cmd_valid <= 1'b1;
        cmd       <= step_cmd;
        cmd_wdata <= step_byte;
        pend      <= 1'b1;
      end else if (eng_done) begin
        pend <= 1'b0;
        case (step)
          S_START: step <= S_SEL;
          S_SEL: begin
            if (eng_ack) begin
              step <= (op_q == OP_NONE) ? S_STOP : S_ADDR;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              if (poll_cnt + 1'b1 >= PCW'(MAX_POLLS)) begin
                timeout_err <= 1'b1;
                step        <= S_STOP;
              end else begin
                step <= S_START;
              end
            end
          end
          S_ADDR:   step <= (op_q == OP_WR) ? S_DATA : S_RSTART;
          S_DATA:   step <= S_STOP;
          S_RSTART: step <= S_RSEL;
          S_RSEL:   step <= S_READ;
          S_READ: begin
            rd_data <= eng_rdata;
            step    <= S_STOP;
          end
          default: begin
            step <= S_IDLE;
            done <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk #(
  parameter int MAX_POLLS = 16,
  parameter int PCW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go,
  input logic           busy,
  input logic           done,
  input logic           timeout_err,
  input logic [PCW-1:0] poll_cnt,
  input logic           cmd_valid,
  input logic [2:0]     cmd
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !cmd_valid && !done && !timeout_err);

  a_r2_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy |=> busy);

  a_r2_first_cmd_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> cmd_valid && cmd == 3'd0);

  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= PCW'(MAX_POLLS));

  a_r8_flag_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !go |=> $stable(timeout_err));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $fell(busy));

  a_r10_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r10_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

endmodule

bind ackpoll_seq ackpoll_seq_chk #(.MAX_POLLS(MAX_POLLS), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .timeout_err(timeout_err), .poll_cnt(poll_cnt),
  .cmd_valid(cmd_valid), .cmd(cmd)
);

// File: tb/ackpoll_seq_bench.sv
module ackpoll_seq_bench;
  localparam int MAXP = 4;
  localparam int PCW  = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [6:0] dev_addr = 7'h50;
  logic [7:0] byte_addr = 8'h00, wr_data = 8'h00;
  logic busy, done, timeout_err, cmd_valid;
  logic [PCW-1:0] poll_cnt;
  logic [7:0] rd_data, cmd_wdata;
  logic [2:0] cmd;
  logic eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0] eng_rdata = 8'h00;

  int errors = 0, checks = 0, cyc = 0;
  int nacks_left = 0;
  int dly = 0;
  logic pend_ack = 1'b0;
  logic [10:0] log_q [0:63];
  int log_n = 0;
  logic [10:0] exp_q [0:63];
  int exp_n = 0;

  always #2.5 clk = ~clk;

  ackpoll_seq #(.MAX_POLLS(MAXP)) u_ackpoll_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .op_kind(op_kind), .dev_addr(dev_addr),
    .byte_addr(byte_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .timeout_err(timeout_err), .poll_cnt(poll_cnt), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd(cmd), .cmd_wdata(cmd_wdata),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
  );

  // byte engine model: answers each command three cycles later
  always @(posedge clk) begin
    cyc <= cyc + 1;
    eng_done <= 1'b0;
    if (cmd_valid) begin
      if (log_n < 64) log_q[log_n] <= {cmd, cmd_wdata};
      log_n <= log_n + 1;
      dly <= 3;
      pend_ack <= 1'b1;
      if (cmd == 3'd1 && cmd_wdata == {dev_addr, 1'b0}) begin
        if (nacks_left > 0) begin
          pend_ack <= 1'b0;
          nacks_left <= nacks_left - 1;
        end
      end
    end else if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        eng_done  <= 1'b1;
        eng_ack   <= pend_ack;
        eng_rdata <= 8'hA5 ^ byte_addr;
      end
    end
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks = checks + 1;
    if (act !== expv) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [7:0] b);
    exp_q[exp_n] = {c, b};
    exp_n = exp_n + 1;
  endtask

  task automatic poll_pair();
    push(3'd0, 8'h00);
    push(3'd1, {dev_addr, 1'b0});
  endtask

  task automatic run(input logic [1:0] op, input int nacks, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    log_n = 0; exp_n = 0; nacks_left = nacks;
    op_kind = op; byte_addr = a; wr_data = d; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic cmp_log(input string req);
    chk(req, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(req, {21'd0, log_q[i] & ((log_q[i][10:8] == 3'd1) ? 11'h7FF : 11'h700)},
               {21'd0, exp_q[i] & ((exp_q[i][10:8] == 3'd1) ? 11'h7FF : 11'h700)});
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 timeout_err", timeout_err, 0);
  endtask

  task automatic t_write_ready();
    run(2'd1, 0, 8'h12, 8'h3C);
    poll_pair(); push(3'd1, 8'h12); push(3'd1, 8'h3C); push(3'd3, 0);
    cmp_log("R5 write, ready at once");
    chk("R2 busy falls with done (R9)", busy, 0);
    chk("R4 poll_cnt", poll_cnt, 0);
  endtask

  task automatic t_write_polled();
    run(2'd1, 3, 8'h07, 8'hE1);
    for (int i = 0; i < 4; i++) poll_pair();
    push(3'd1, 8'h07); push(3'd1, 8'hE1); push(3'd3, 0);
    cmp_log("R3 R4 R5 write after 3 refusals");
    chk("R4 poll_cnt", poll_cnt, 3);
    chk("R8 no timeout", timeout_err, 0);
  endtask

  task automatic t_read_polled();
    run(2'd2, 2, 8'h41, 8'h00);
    for (int i = 0; i < 3; i++) poll_pair();
    push(3'd1, 8'h41); push(3'd4, 0); push(3'd1, {dev_addr, 1'b1});
    push(3'd2, 0); push(3'd3, 0);
    cmp_log("R6 random read after 2 refusals");
    chk("R6 rd_data", rd_data, 8'hA5 ^ 8'h41);
  endtask

  task automatic t_none();
    run(2'd0, 1, 8'h00, 8'h00);
    poll_pair(); poll_pair(); push(3'd3, 0);
    cmp_log("R7 no next operation");
  endtask

  task automatic t_timeout();
    run(2'd1, 10, 8'h20, 8'h55);
    for (int i = 0; i < MAXP; i++) poll_pair();
    push(3'd3, 0);
    cmp_log("R8 limit reached");
    chk("R8 timeout_err", timeout_err, 1);
    chk("R8 poll_cnt", poll_cnt, MAXP);
    repeat (5) @(negedge clk);
    chk("R8 flag held", timeout_err, 1);
    run(2'd0, 0, 8'h00, 8'h00);
    chk("R8 cleared by go", timeout_err, 0);
  endtask

  task automatic t_go_busy();
    @(negedge clk);
    log_n = 0; exp_n = 0; nacks_left = 1;
    op_kind = 2'd0; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (6) @(negedge clk);
    op_kind = 2'd2; byte_addr = 8'h99; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (!done) @(negedge clk);
    poll_pair(); poll_pair(); push(3'd3, 0);
    cmp_log("R9 go while busy ignored");
    repeat (3) @(negedge clk);
    chk("R9 no new run", busy, 0);
    chk("R10 no command when idle", cmd_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_write_ready();
    t_write_polled();
    t_read_polled();
    t_none();
    t_timeout();
    t_go_busy();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule